// File: doc/BRIEF.md
# I2C Transfer Length Controller

This block sits beside the bit-level engine of an I2C master and decides how a transfer ends. Software writes one 32-bit control word that carries a byte count, a reload choice, an automatic-end choice and a request to send or receive a packet-error-check byte. The engine pulses `byte_done` once for each byte that completes. The controller counts the remaining bytes down and acts when the last one finishes.

There are three ways a segment can end. In software end it raises a completion flag and holds SCL low until software acts. In automatic end it asks the engine for a STOP condition. In reload mode it raises a reload flag and holds SCL low until software writes a fresh count, and the transfer then goes on. When a PEC byte is requested outside reload mode, the last counted byte is the PEC byte and `pec_slot` marks it. The request clears itself once that byte is done, and also on STOP, on an address match and when the block is disabled.

Top module: `i2c_len_ctrl`

## Requirements
- R1: After reset, `rd_data`, `bytes_left`, `tc_flag`, `tcr_flag`, `hold_scl`, `stop_req` and `pec_slot` are all zero.
- R2: In `rd_data`, bit 26 is the PEC request, bit 25 is automatic end, bit 24 is reload and bits 23:16 are the byte count. Bits 31:27 and 15:0 always read 0.
- R3: A write (`wr_en`=1) with `start_pend`=0 stores bits 23:16 as the byte count and loads `bytes_left` with it on the next cycle. With `start_pend`=1 the count field and `bytes_left` are left unchanged, while bits 25:24 are still stored.
- R4: Each `byte_done` while `bytes_left` is nonzero lowers it by one. A `byte_done` at zero has no effect. A count write in the same cycle takes priority.
- R5: With reload=0 and automatic end=0, the `byte_done` that brings `bytes_left` from 1 to 0 sets `tc_flag` and `hold_scl` on the next cycle.
- R6: With reload=0 and automatic end=1, that final byte makes `stop_req` high for exactly one cycle, and `hold_scl` stays 0.
- R7: With reload=1, the final byte sets `tcr_flag` and `hold_scl`, and `stop_req` stays 0 whatever the automatic-end bit is. An accepted count write then clears `tcr_flag` and `hold_scl` and reloads `bytes_left`.
- R8: Software can only set the PEC request. A write with bit 26 = 0 leaves it unchanged.
- R9: `pec_slot` is 1 exactly while the PEC request is 1, reload is 0 and `bytes_left` is 1. When the final byte completes in that state, the PEC request clears.
- R10: `stop_seen` or `addr_match` clears the PEC request on the next cycle, unless the same cycle's write sets it.
- R11: With reload=1, the PEC request has no effect: `pec_slot` stays 0, and the request survives the final byte.
- R12: `enable`=0 clears `bytes_left`, `tc_flag`, `tcr_flag` and the PEC request on the next cycle.
- R13: `stop_seen` clears `tc_flag` and `tcr_flag`, which releases `hold_scl`, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; low clears the count, flags and PEC request |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word written |
| start_pend | input | 1 | A START request is pending; count writes are refused |
| byte_done | input | 1 | One byte finished on the bus |
| stop_seen | input | 1 | A STOP condition was observed |
| addr_match | input | 1 | An address match was received |
| rd_data | output | 32 | Control word readback |
| bytes_left | output | 8 | Bytes remaining in the current segment |
| tc_flag | output | 1 | Transfer complete (software end) |
| tcr_flag | output | 1 | Transfer complete, reload pending |
| hold_scl | output | 1 | Engine must keep SCL low |
| stop_req | output | 1 | One-cycle request for an automatic STOP |
| pec_slot | output | 1 | The current byte is the PEC byte |

## Verification
The bench builds the block with its default parameters: an 8-bit count and PEC support present. This makes the full PEC set, slot and clear path reachable, together with its interplay with the reload and automatic-end priorities. The random writes mostly use counts of 0 to 5 so that segment ends happen often. Rare full-width counts test that the counter carries wide values correctly. Directed sequences cover a refused count write under a pending START, byte strobes at zero and simultaneous set and clear of the PEC request.

// File: rtl/i2c_len_pkg.sv
`timescale 1ns/1ps
package i2c_len_pkg;
  localparam int REG_W    = 32;
  localparam int POS_PEC  = 26;
  localparam int POS_AUTO = 25;
  localparam int POS_RLD  = 24;
  localparam int POS_CNT  = 16;

  typedef enum logic [1:0] {
    END_SOFT   = 2'd0,
    END_AUTO   = 2'd1,
    END_RELOAD = 2'd2
  } end_mode_e;

  // reload outranks automatic end
  function automatic end_mode_e pick_end(input logic rld, input logic aut);
    if (rld)      return END_RELOAD;
    else if (aut) return END_AUTO;
    else          return END_SOFT;
  endfunction
endpackage

// File: rtl/i2c_len_regs.sv
`timescale 1ns/1ps
module i2c_len_regs
  import i2c_len_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter bit PEC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             start_pend,
  input  logic             pec_clr,
  output logic             pec_req,
  output logic             auto_end,
  output logic             reload,
  output logic [CNT_W-1:0] nbytes,
  output logic             cnt_wr,
  output logic [REG_W-1:0] rd_data
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  assign cnt_wr = wr_en & ~start_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_end <= 1'b0;
      reload   <= 1'b0;
      nbytes   <= '0;
    end else begin
      if (wr_en) begin
        auto_end <= wr_data[POS_AUTO];
        reload   <= wr_data[POS_RLD];
      end
      if (cnt_wr) nbytes <= wr_data[POS_CNT +: CNT_W];
    end
  end

  generate
    if (PEC_EN) begin : g_pec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pec_req <= 1'b0;
        else if (!enable) pec_req <= 1'b0;
        else              pec_req <= (pec_req & ~pec_clr) | (wr_en & wr_data[POS_PEC]);
      end
    end else begin : g_nopec
      assign pec_req = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_data                   = '0;
    rd_data[POS_PEC]          = pec_req;
    rd_data[POS_AUTO]         = auto_end;
    rd_data[POS_RLD]          = reload;
    rd_data[POS_CNT +: CNT_W] = nbytes;
  end
endmodule

// File: rtl/i2c_len_count.sv
`timescale 1ns/1ps
module i2c_len_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             byte_done,
  output logic [CNT_W-1:0] remain,
  output logic             on_last,
  output logic             last_byte
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  assign on_last   = (remain == ONE);
  assign last_byte = enable & byte_done & on_last & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain <= '0;
    else if (!enable)   remain <= '0;
    else if (load)      remain <= load_val;
    else if (byte_done) remain <= step_down(remain);
  end
endmodule

// File: rtl/i2c_len_endctl.sv
`timescale 1ns/1ps
module i2c_len_endctl
  import i2c_len_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic restart,
  input  logic stop_seen,
  input  logic last_byte,
  input  logic on_last,
  input  logic reload,
  input  logic auto_end,
  input  logic pec_req,
  output logic tc_flag,
  output logic tcr_flag,
  output logic stop_req,
  output logic pec_slot,
  output logic pec_done
);
  end_mode_e mode;
  logic      flag_clr;

  assign mode     = pick_end(reload, auto_end);
  assign flag_clr = ~enable | restart | stop_seen;
  assign pec_slot = pec_req & ~reload & on_last;
  assign pec_done = last_byte & pec_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag  <= 1'b0;
      tcr_flag <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      stop_req <= last_byte && (mode == END_AUTO);
      if (flag_clr) begin
        tc_flag  <= 1'b0;
        tcr_flag <= 1'b0;
      end else if (last_byte) begin
        if (mode == END_SOFT)   tc_flag  <= 1'b1;
        if (mode == END_RELOAD) tcr_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_len_ctrl.sv
`timescale 1ns/1ps
module i2c_len_ctrl
  import i2c_len_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter bit PEC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             start_pend,
  input  logic             byte_done,
  input  logic             stop_seen,
  input  logic             addr_match,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] bytes_left,
  output logic             tc_flag,
  output logic             tcr_flag,
  output logic             hold_scl,
  output logic             stop_req,
  output logic             pec_slot
);
  logic             pec_req, auto_end, reload, cnt_wr;
  logic             on_last, last_byte, pec_done, pec_clr;
  logic [CNT_W-1:0] nbytes;

  assign pec_clr  = stop_seen | addr_match | pec_done;
  assign hold_scl = tc_flag | tcr_flag;

  i2c_len_regs #(.CNT_W(CNT_W), .PEC_EN(PEC_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
    .start_pend(start_pend), .pec_clr(pec_clr), .pec_req(pec_req),
    .auto_end(auto_end), .reload(reload), .nbytes(nbytes), .cnt_wr(cnt_wr),
    .rd_data(rd_data)
  );

  i2c_len_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(cnt_wr), .load_val(nbytes_in()),
    .byte_done(byte_done), .remain(bytes_left), .on_last(on_last), .last_byte(last_byte)
  );

  i2c_len_endctl u_end (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(cnt_wr), .stop_seen(stop_seen),
    .last_byte(last_byte), .on_last(on_last), .reload(reload), .auto_end(auto_end),
    .pec_req(pec_req), .tc_flag(tc_flag), .tcr_flag(tcr_flag), .stop_req(stop_req),
    .pec_slot(pec_slot), .pec_done(pec_done)
  );

  logic unused_nbytes;
  assign unused_nbytes = ^nbytes;

  function automatic logic [CNT_W-1:0] nbytes_in();
    return wr_data[POS_CNT +: CNT_W];
  endfunction
endmodule

// File: rtl/i2c_len_chk.sv
`timescale 1ns/1ps
module i2c_len_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             start_pend,
  input logic             stop_seen,
  input logic [31:0]      rd_data,
  input logic [CNT_W-1:0] bytes_left,
  input logic             tc_flag,
  input logic             tcr_flag,
  input logic             hold_scl,
  input logic             stop_req,
  input logic             pec_slot,
  input logic             cnt_wr,
  input logic             last_byte
);
  logic unused_wd;
  assign unused_wd = ^{wr_data[31:27], wr_data[25:0]};

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:27] == 5'd0) && (rd_data[15:0] == 16'd0));

  assert_count_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && start_pend) |=> $stable(rd_data[16 +: CNT_W]));

  assert_no_rise_without_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_left > $past(bytes_left)) |-> $past(cnt_wr));

  assert_tc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> ($past(last_byte) && !$past(rd_data[24]) && !$past(rd_data[25])));

  assert_stop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> ($past(last_byte) && $past(rd_data[25]) && !$past(rd_data[24])));

  assert_stop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  assert_stop_no_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !hold_scl);

  assert_tcr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcr_flag) |-> ($past(last_byte) && $past(rd_data[24])));

  assert_pec_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !(wr_en && wr_data[26])) |=> !rd_data[26]);

  assert_pec_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pec_slot |-> !rd_data[24]);

  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((bytes_left == '0) && !tc_flag && !tcr_flag && !rd_data[26]));

  assert_stop_releases_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!tc_flag && !tcr_flag));
endmodule

bind i2c_len_ctrl i2c_len_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
  .start_pend(start_pend), .stop_seen(stop_seen), .rd_data(rd_data),
  .bytes_left(bytes_left), .tc_flag(tc_flag), .tcr_flag(tcr_flag),
  .hold_scl(hold_scl), .stop_req(stop_req), .pec_slot(pec_slot),
  .cnt_wr(cnt_wr), .last_byte(last_byte)
);

// File: tb/sim_i2c_len_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_len_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, wr_en = 1'b0, start_pend = 1'b0;
  logic        byte_done = 1'b0, stop_seen = 1'b0, addr_match = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic [7:0]  bytes_left;
  logic        tc_flag, tcr_flag, hold_scl, stop_req, pec_slot;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // model state
  logic       m_pec = 0, m_auto = 0, m_rel = 0, m_tc = 0, m_tcr = 0, m_stop = 0;
  logic [7:0] m_nb = 0, m_rem = 0;

  always #2.5 clk = ~clk;

  i2c_len_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
    .start_pend(start_pend), .byte_done(byte_done), .stop_seen(stop_seen),
    .addr_match(addr_match), .rd_data(rd_data), .bytes_left(bytes_left),
    .tc_flag(tc_flag), .tcr_flag(tcr_flag), .hold_scl(hold_scl),
    .stop_req(stop_req), .pec_slot(pec_slot)
  );

  function automatic logic [31:0] mk(input logic p, input logic a, input logic r,
                                     input logic [7:0] n);
    return {5'd0, p, a, r, n, 16'd0};
  endfunction

  function automatic logic exp_slot();
    return m_pec & ~m_rel & (m_rem == 8'd1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic cw, last, slot, n_pec, n_tc, n_tcr;
    logic [7:0] n_rem;
    cw   = wr_en & ~start_pend;
    last = enable & byte_done & (m_rem == 8'd1) & ~cw;
    slot = exp_slot();
    n_tc = m_tc; n_tcr = m_tcr;
    if (!enable || cw || stop_seen) begin n_tc = 0; n_tcr = 0; end
    else if (last) begin
      if (m_rel) n_tcr = 1; else if (!m_auto) n_tc = 1;
    end
    if (!enable) n_rem = 0;
    else if (cw) n_rem = wr_data[23:16];
    else if (byte_done && m_rem != 0) n_rem = m_rem - 8'd1;
    else n_rem = m_rem;
    if (!enable) n_pec = 0;
    else n_pec = (m_pec & ~(stop_seen | addr_match | (last & slot))) | (wr_en & wr_data[26]);
    m_stop = last & ~m_rel & m_auto;
    m_tc = n_tc; m_tcr = n_tcr; m_rem = n_rem; m_pec = n_pec;
    if (wr_en) begin m_auto = wr_data[25]; m_rel = wr_data[24]; end
    if (cw) m_nb = wr_data[23:16];
  endtask

  task automatic compare_all();
    chk("R2 rd_data", rd_data, mk(m_pec, m_auto, m_rel, m_nb));
    chk("R4 bytes_left", {24'd0, bytes_left}, {24'd0, m_rem});
    chk("R5 tc_flag", {31'd0, tc_flag}, {31'd0, m_tc});
    chk("R5 hold_scl", {31'd0, hold_scl}, {31'd0, m_tc | m_tcr});
    chk("R6 stop_req", {31'd0, stop_req}, {31'd0, m_stop});
    chk("R7 tcr_flag", {31'd0, tcr_flag}, {31'd0, m_tcr});
    chk("R9 pec_slot", {31'd0, pec_slot}, {31'd0, exp_slot()});
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0; byte_done = 0; stop_seen = 0; addr_match = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d; cyc();
  endtask

  task automatic bd(input int n);
    for (int i = 0; i < n; i++) begin byte_done = 1; cyc(); end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 outputs", {24'd0, bytes_left}, 32'd0);
    chk("R1 flags", {27'd0, tc_flag, tcr_flag, hold_scl, stop_req, pec_slot}, 32'd0);
    rst_n = 1; enable = 1;
    @(negedge clk);

    // R5 software end, then R13 release by STOP
    wr(mk(0, 0, 0, 8'd3));
    chk("R3 load", {24'd0, bytes_left}, 32'd3);
    bd(3);
    chk("R5 tc set", {30'd0, tc_flag, hold_scl}, 32'd3);
    bd(1);
    chk("R4 zero strobe", {24'd0, bytes_left}, 32'd0);
    stop_seen = 1; cyc();
    chk("R13 released", {30'd0, tc_flag, hold_scl}, 32'd0);

    // R6 automatic end
    wr(mk(0, 1, 0, 8'd2));
    bd(2);
    chk("R6 stop pulse", {30'd0, stop_req, hold_scl}, 32'd2);
    cyc();
    chk("R6 pulse ends", {31'd0, stop_req}, 32'd0);

    // R7 reload with automatic end ignored
    wr(mk(0, 1, 1, 8'd2));
    bd(2);
    chk("R7 tcr hold", {29'd0, tcr_flag, hold_scl, stop_req}, 32'd6);
    wr(mk(0, 0, 0, 8'd1));
    chk("R7 reloaded", {22'd0, tcr_flag, hold_scl, bytes_left}, 32'd1);
    bd(1);
    chk("R5 after reload", {31'd0, tc_flag}, 32'd1);

    // R3 refused count write under pending START
    wr(mk(0, 0, 0, 8'd4));
    start_pend = 1;
    wr(mk(0, 1, 0, 8'd9));
    chk("R3 count kept", rd_data, mk(0, 1, 0, 8'd4));
    chk("R3 remain kept", {24'd0, bytes_left}, 32'd4);
    start_pend = 0;

    // R8 set-only, R9 slot and self clear
    wr(mk(1, 1, 0, 8'd2));
    wr(mk(0, 1, 0, 8'd2));
    chk("R8 write zero ignored", {31'd0, rd_data[26]}, 32'd1);
    bd(1);
    chk("R9 slot on last", {31'd0, pec_slot}, 32'd1);
    bd(1);
    chk("R9 pec cleared", {30'd0, rd_data[26], pec_slot}, 32'd0);

    // R11 PEC ignored in reload mode
    wr(mk(1, 0, 1, 8'd1));
    chk("R11 no slot", {31'd0, pec_slot}, 32'd0);
    bd(1);
    chk("R11 pec kept", {30'd0, rd_data[26], tcr_flag}, 32'd3);

    // R10 address match clears; set wins over stop in same cycle
    addr_match = 1; cyc();
    chk("R10 addr clear", {31'd0, rd_data[26]}, 32'd0);
    stop_seen = 1; wr(mk(1, 0, 0, 8'd5));
    chk("R10 set wins", {31'd0, rd_data[26]}, 32'd1);

    // R12 disable
    bd(1);
    enable = 0; cyc();
    chk("R12 cleared", {21'd0, rd_data[26], tc_flag, tcr_flag, bytes_left}, 32'd0);
    enable = 1; cyc();

    // R4 wide count carried
    wr(mk(0, 0, 0, 8'd255));
    chk("R4 wide load", {24'd0, bytes_left}, 32'd255);
    bd(1);
    chk("R4 wide step", {24'd0, bytes_left}, 32'd254);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] n;
      n = ($urandom % 16 == 0) ? 8'($urandom) : 8'($urandom % 6);
      enable     = ($urandom % 100) != 0;
      start_pend = ($urandom % 5) == 0;
      byte_done  = ($urandom % 10) < 4;
      stop_seen  = ($urandom % 30) == 0;
      addr_match = ($urandom % 30) == 0;
      wr_en      = ($urandom % 10) == 0;
      wr_data    = {5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), n, 16'($urandom)};
      cyc();
    end

    finished = 1;
    report();
    $finish;
  end
endmodule